// File: doc/BRIEF.md
# Hart Debug Status Tracker

This block produces the three status lines that a hart reports to an external debug module. The lines are have-reset, running and halted. It watches the active-low reset, the fetch-enable input, the debug request and the core's own debug-mode flag. From these it works out which of the three debug states the hart is in.

While reset is applied, and for as long as fetch-enable has not been sampled high afterwards, the hart reports have-reset. Once fetch-enable has been seen high, a fixed countdown of `EXIT_DELAY` clock edges runs. When it ends, the hart leaves the have-reset phase and does not return to it until the next reset.

A debug request seen at any edge of that phase is remembered. The first status after the phase is then halted, and running is never shown in between. Halted is held until the core raises its debug-mode flag. From then on, halted follows the debug-mode flag and running follows its inverse. The block has no data path: all pins are plain control and status levels, with no valid/ready handshake.

Top module: `hart_dbg_status`

## Requirements
- R1: While `rst_n` is low, `st_reset` is high and `st_running` and `st_halted` are low, asynchronously to the clock.
- R2: Let edge E be the first rising clock edge after reset release at which `fetch_en` is sampled high. The outputs leave have-reset directly after edge E + `EXIT_DELAY` - 1 (default `EXIT_DELAY` = 3). If `fetch_en` is never sampled high, have-reset is held indefinitely.
- R3: At every cycle exactly one of `st_reset`, `st_running` and `st_halted` is high.
- R4: After the have-reset phase, `st_halted` equals the value of `dbg_mode` sampled at the previous rising edge, and `st_running` is its inverse. R6 describes the one exception.
- R5: Suppose `dbg_req` is sampled high at any edge from reset release up to and including the exit edge of R2. The first status after have-reset is then halted, and running is never shown before it.
- R6: The halt caused by R5 is held even while `dbg_mode` is low, until `dbg_mode` is first sampled high. After that, R4 applies.
- R7: Once `fetch_en` has been sampled high, dropping it later neither stops the countdown nor returns the block to have-reset.
- R8: After the have-reset phase ends, `st_reset` stays low until `rst_n` is asserted again.
- R9: After the have-reset phase, `dbg_req` has no direct effect on the outputs. Halted is reported only through `dbg_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en | input | 1 | Fetch-enable from the system; its first high sample starts the exit countdown |
| dbg_req | input | 1 | Halt request from the debug module |
| dbg_mode | input | 1 | High while the core executes in debug mode |
| st_reset | output | 1 | Status: hart has been reset, not yet available |
| st_running | output | 1 | Status: hart runs normal code |
| st_halted | output | 1 | Status: hart is halted in debug mode |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that `dbg_mode` is a level the core holds for whole cycles. They assume nothing about the ordering of `dbg_req` and `dbg_mode`, because the block must stay consistent for any combination. The stimulus changes every input two nanoseconds after a rising edge, so all inputs are stable at each sampling edge. Debug-mode is moved both with and without a preceding request, including the case where it is already high when the countdown ends.

// File: rtl/hds_pkg.sv
package hds_pkg;
  typedef enum logic {
    PH_RESET = 1'b0,
    PH_LIVE  = 1'b1
  } hds_phase_e;
endpackage

// File: rtl/hds_fetch_gate.sv
module hds_fetch_gate #(
  parameter int EXIT_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fetch_en,
  output logic exit_now
);
  localparam int CW = (EXIT_DELAY > 1) ? $clog2(EXIT_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(EXIT_DELAY - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          seen;

  assign seen     = armed_q | fetch_en;
  assign exit_now = active & seen & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (active && seen) begin
      armed_q <= 1'b1;
      if (!exit_now) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hds_req_latch.sv
module hds_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic live,
  input  logic exit_now,
  input  logic dbg_req,
  input  logic dbg_mode,
  output logic pend_now,
  output logic hold_q
);
  logic pend_q;

  assign pend_now = pend_q | dbg_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (active) pend_q <= pend_now;
      if (exit_now)  hold_q <= pend_now & ~dbg_mode;
      else if (live) hold_q <= hold_q & ~dbg_mode;
    end
  end
endmodule

// File: rtl/hds_phase_ctrl.sv
module hds_phase_ctrl
  import hds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exit_now,
  input  logic pend_now,
  input  logic hold_q,
  input  logic dbg_mode,
  output logic active,
  output logic live,
  output logic st_reset,
  output logic st_running,
  output logic st_halted
);
  hds_phase_e phase_q;
  logic       halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_RESET;
      halted_q <= 1'b0;
    end else begin
      if (phase_q == PH_RESET && exit_now) phase_q <= PH_LIVE;
      if (exit_now)                 halted_q <= pend_now | dbg_mode;
      else if (phase_q == PH_LIVE)  halted_q <= dbg_mode | hold_q;
    end
  end

  assign active     = (phase_q == PH_RESET);
  assign live       = (phase_q == PH_LIVE);
  assign st_reset   = active;
  assign st_halted  = live & halted_q;
  assign st_running = live & ~halted_q;
endmodule

// File: rtl/hart_dbg_status.sv
module hart_dbg_status #(
  parameter int EXIT_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_en,
  input  logic dbg_req,
  input  logic dbg_mode,
  output logic st_reset,
  output logic st_running,
  output logic st_halted
);
  logic active, live, exit_now, pend_now, hold_q;

  hds_fetch_gate #(.EXIT_DELAY(EXIT_DELAY)) u_gate (
    .clk(clk), .rst_n(rst_n), .active(active),
    .fetch_en(fetch_en), .exit_now(exit_now)
  );

  hds_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .active(active), .live(live),
    .exit_now(exit_now), .dbg_req(dbg_req), .dbg_mode(dbg_mode),
    .pend_now(pend_now), .hold_q(hold_q)
  );

  hds_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .exit_now(exit_now), .pend_now(pend_now),
    .hold_q(hold_q), .dbg_mode(dbg_mode), .active(active), .live(live),
    .st_reset(st_reset), .st_running(st_running), .st_halted(st_halted)
  );
endmodule

// File: rtl/hds_status_chk.sv
module hds_status_chk (
  input logic clk,
  input logic rst_n,
  input logic fetch_en,
  input logic dbg_req,
  input logic dbg_mode,
  input logic st_reset,
  input logic st_running,
  input logic st_halted
);
  logic fe_seen_q, req_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_seen_q  <= 1'b0;
      req_seen_q <= 1'b0;
    end else if (st_reset) begin
      fe_seen_q  <= fe_seen_q | fetch_en;
      req_seen_q <= req_seen_q | dbg_req;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (st_reset && !st_running && !st_halted));

  p_one_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_reset, st_running, st_halted}) == 1);

  p_wait_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_reset && !fe_seen_q && !fetch_en) |=> st_reset);

  p_no_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_reset |=> !st_reset);

  p_direct_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_reset) && req_seen_q) |-> st_halted);

  p_follow_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_reset && $past(dbg_mode)) |-> st_halted);

  p_run_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_reset && $past(st_running) && !$past(dbg_mode)) |-> st_running);
endmodule

bind hart_dbg_status hds_status_chk u_status_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .dbg_req(dbg_req),
  .dbg_mode(dbg_mode), .st_reset(st_reset), .st_running(st_running),
  .st_halted(st_halted)
);

// File: tb/hart_dbg_status_bench.sv
module hart_dbg_status_bench;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, fetch_en = 1'b0, dbg_req = 1'b0, dbg_mode = 1'b0;
  logic st_reset, st_running, st_halted;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";
  bit finished = 0;
  bit saw_running = 0;

  always #4 clk = ~clk;

  hart_dbg_status #(.EXIT_DELAY(DLY)) u_hart_dbg_status (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .dbg_req(dbg_req),
    .dbg_mode(dbg_mode), .st_reset(st_reset), .st_running(st_running),
    .st_halted(st_halted)
  );

  // behavioural reference
  bit m_live = 0, m_pend = 0, m_hold = 0, m_halt = 0;
  int m_arm = -1;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_live = 0; m_arm = -1; m_pend = 0; m_hold = 0; m_halt = 0;
    end else if (!m_live) begin
      m_pend = m_pend | dbg_req;
      if (m_arm < 0 && fetch_en) m_arm = 0;
      if (m_arm >= 0) begin
        if (m_arm == DLY - 1) begin
          m_live = 1;
          m_hold = m_pend && !dbg_mode;
          m_halt = m_pend || dbg_mode;
        end else m_arm++;
      end
    end else begin
      m_halt = dbg_mode || m_hold;
      m_hold = m_hold && !dbg_mode;
    end
  end

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (reset,running,halted) t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic er, eh;
      er = !rst_n || !m_live;
      eh = !er && m_halt;
      chk(tag, {st_reset, st_running, st_halted}, {er, !er && !eh, eh});
      chk("R3", 3'(st_reset + st_running + st_halted), 3'd1);
      if (st_running) saw_running = 1;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tag = "R1"; wait_cyc(5);
    rst_n = 1; tag = "R2"; wait_cyc(15);
    tag = "R7"; fetch_en = 1; wait_cyc(1); fetch_en = 0; wait_cyc(6);
    tag = "R4"; dbg_mode = 1; wait_cyc(4); dbg_mode = 0; wait_cyc(3);
    tag = "R9"; dbg_req = 1; wait_cyc(2); dbg_req = 0; wait_cyc(3);
    tag = "R8"; wait_cyc(3);
    tag = "R1"; rst_n = 0; wait_cyc(3);
    rst_n = 1; saw_running = 0;
    tag = "R5"; dbg_req = 1; wait_cyc(2); dbg_req = 0; wait_cyc(2);
    fetch_en = 1; wait_cyc(6);
    tag = "R6"; wait_cyc(4);
    chk("R5 no running seen", {2'b0, saw_running}, 3'b0);
    dbg_mode = 1; wait_cyc(3); dbg_mode = 0; wait_cyc(4);
    tag = "R1"; rst_n = 0; fetch_en = 0; wait_cyc(2);
    rst_n = 1; wait_cyc(2); saw_running = 0;
    tag = "R5"; fetch_en = 1; dbg_req = 1; wait_cyc(1); dbg_req = 0; wait_cyc(6);
    chk("R5 coincident no running", {2'b0, saw_running}, 3'b0);
    dbg_mode = 1; wait_cyc(2); dbg_mode = 0; wait_cyc(3);
    tag = "R1"; rst_n = 0; wait_cyc(2);
    tag = "R4"; rst_n = 1; dbg_mode = 1; wait_cyc(6); dbg_mode = 0; wait_cyc(3);
    finish_run();
  end
endmodule